// File: doc/BRIEF.md
# Second-Operand Shifter with Carry Generation

This block forms the second source operand of a 32-bit data-processing datapath, together with the shifter carry that the flag logic needs for logical operations. It is purely combinational. It takes the instruction word, the value of the register to be shifted, the value of the register that may hold a shift amount, and the current carry flag. From these it produces the operand, a carry-out and a carry-valid strobe.

Three operand forms are decoded. The first is an 8-bit immediate rotated by an even amount. The second is a register shifted by a 5-bit amount taken from the instruction. The third is a register shifted by an amount held in the low byte of another register. Each shifted form applies one of four shift kinds: logical left, logical right, arithmetic right and rotate right. An encoded immediate amount of zero has a special meaning that depends on the shift kind. The caller fetches the registers. Whenever carry-valid is low, it keeps its carry flag unchanged.

Top module: `op2_shifter`

## Requirements
- R1: When instruction bit 25 is 1, the operand is instruction bits 7:0 zero-extended to 32 bits and rotated right by two times the value of bits 11:8.
- R2: In the rotated-immediate form, a nonzero rotate gives carry-out equal to bit 31 of the operand, with carry-valid 1. A rotate of zero gives carry-valid 0.
- R3: When bit 25 is 0, bits 6:5 select the shift kind (00 logical left, 01 logical right, 10 arithmetic right, 11 rotate right) and bit 4 selects a register amount (1) or an immediate amount taken from bits 11:7 (0). A logical-left immediate shift by s > 0 gives carry-out equal to input bit 32-s. A logical-left immediate shift by 0 passes the value through unchanged.
- R4: For logical-right and arithmetic-right immediate shifts, an encoded amount of 0 acts as a shift by 32. Logical right then gives 0 and arithmetic right gives 32 copies of bit 31. In both cases carry-out is input bit 31.
- R5: A rotate-right immediate shift with encoded amount 0 shifts right by one bit and places the incoming carry in bit 31. Its carry-out is input bit 0.
- R6: Right shifts and rotates by a nonzero amount s below 32 give carry-out equal to input bit s-1.
- R7: In the register-amount form only the low 8 bits of the amount register count. When those 8 bits are zero, the operand equals the input.
- R8: With a register amount of exactly 32, logical left gives 0 with carry bit 0, and logical right gives 0 with carry bit 31. Above 32, both give 0 with carry 0.
- R9: An arithmetic right shift by a register amount of 32 or more gives 32 copies of bit 31, and carry-out is bit 31.
- R10: A rotate by a register amount uses that amount modulo 32. A nonzero multiple of 32 leaves the value unchanged, and carry-out is bit 31.
- R11: Carry-valid is 0 exactly when the effective amount is zero (R2, R3, R7). In that case carry-out equals carry-in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instrWord | input | 32 | Instruction word holding the operand-form fields |
| rmValue | input | 32 | Value of the register to be shifted |
| rsValue | input | 32 | Value of the register holding a shift amount |
| carryIn | input | 1 | Current carry flag |
| opnd | output | 32 | Generated second operand |
| carryOut | output | 1 | Shifter carry-out |
| carryValid | output | 1 | 1 when carryOut should update the carry flag |

## Verification
Directed words place single set bits and sign bits at the edges of the word. This separates the carry-out of each shift kind at amounts 1, 31, 32, 33 and well above. It also separates the reinterpretation of a zero immediate amount from a true pass-through. Register amounts whose upper bits are set while the low byte is zero show whether only the low byte is used. Multiples of 32 show whether rotation is taken modulo 32. Random instruction words and register values then cover every form against a bit-serial reference model. The same random values are used with both carry-in values, so that pass-through and one-bit rotate-through-carry cases show whether carry-in is propagated.

// File: rtl/op2_pkg.sv
package op2_pkg;
  localparam int DATA_W = 32;
  localparam int AMT_W  = 8;
  localparam int IMM_W  = 8;

  typedef enum logic [1:0] {
    SH_LSL = 2'b00,
    SH_LSR = 2'b01,
    SH_ASR = 2'b10,
    SH_ROR = 2'b11
  } shift_e;

  // strobes handed from decode to the shifting datapath
  typedef struct packed {
    logic             immRot;   // source is the rotated immediate
    shift_e           kind;     // shift kind after decode
    logic             rrx;      // one-bit rotate through carry
    logic             hold;     // zero effective amount: pass value and carry
    logic [AMT_W-1:0] amount;   // effective amount (never 0 unless hold/rrx)
    logic [IMM_W-1:0] immVal;   // immediate byte
  } op2_ctl_t;
endpackage

// File: rtl/op2_ctrl.sv
module op2_ctrl
  import op2_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic [DW-1:0] instrWord,
  input  logic [DW-1:0] rsValue,
  output op2_ctl_t      ctl
);
  localparam int IMM_BIT  = 25;
  localparam int REG_BIT  = 4;
  localparam int ROT_LSB  = 8;
  localparam int SAMT_LSB = 7;
  localparam int SAMT_W   = 5;

  logic [SAMT_W-1:0] immAmt;
  logic [3:0]        rotField;

  assign immAmt   = instrWord[SAMT_LSB +: SAMT_W];
  assign rotField = instrWord[ROT_LSB +: 4];

  always_comb begin
    ctl        = '0;
    ctl.immVal = instrWord[IMM_W-1:0];
    ctl.kind   = shift_e'(instrWord[6:5]);
    if (instrWord[IMM_BIT]) begin
      ctl.immRot = 1'b1;
      ctl.kind   = SH_ROR;
      ctl.amount = AMT_W'({rotField, 1'b0});
      ctl.hold   = (rotField == 4'd0);
    end else if (instrWord[REG_BIT]) begin
      ctl.amount = rsValue[AMT_W-1:0];
      ctl.hold   = (rsValue[AMT_W-1:0] == '0);
    end else begin
      ctl.amount = AMT_W'(immAmt);
      if (immAmt == '0) begin
        unique case (shift_e'(instrWord[6:5]))
          SH_LSL:         ctl.hold   = 1'b1;
          SH_LSR, SH_ASR: ctl.amount = AMT_W'(DW);
          SH_ROR:         ctl.rrx    = 1'b1;
          default:        ctl.hold   = 1'b1;
        endcase
      end
    end
  end

  always_comb begin
    if (!instrWord[IMM_BIT] && !instrWord[REG_BIT] &&
        (instrWord[6:5] == 2'b01 || instrWord[6:5] == 2'b10)) begin
      // R4
      imm_amt_chk: assert (ctl.amount != '0 && !ctl.hold);
    end
  end
endmodule

// File: rtl/op2_datapath.sv
module op2_datapath
  import op2_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  op2_ctl_t      ctl,
  input  logic [DW-1:0] rmValue,
  input  logic          carryIn,
  output logic [DW-1:0] opnd,
  output logic          carryOut,
  output logic          carryValid
);
  localparam int SH_W = $clog2(DW);

  logic [DW-1:0]   src;
  logic [DW:0]     lslWide;
  logic [DW:0]     lsrWide;
  logic [DW:0]     asrWide;
  logic [2*DW-1:0] rorWide;
  logic [SH_W-1:0] rotAmt;

  assign src     = ctl.immRot ? DW'(ctl.immVal) : rmValue;
  assign rotAmt  = ctl.amount[SH_W-1:0];
  // extra bit beyond the word catches the last bit shifted out
  assign lslWide = {1'b0, src} << ctl.amount;
  assign lsrWide = {src, 1'b0} >> ctl.amount;
  assign asrWide = $signed({src, 1'b0}) >>> ctl.amount;
  assign rorWide = {src, src} >> rotAmt;

  always_comb begin
    opnd       = src;
    carryOut   = carryIn;
    carryValid = 1'b1;
    if (ctl.hold) begin
      carryValid = 1'b0;
    end else if (ctl.rrx) begin
      opnd     = {carryIn, src[DW-1:1]};
      carryOut = src[0];
    end else begin
      unique case (ctl.kind)
        SH_LSL: {carryOut, opnd} = lslWide;
        SH_LSR: {opnd, carryOut} = lsrWide;
        SH_ASR: {opnd, carryOut} = asrWide;
        SH_ROR: begin
          opnd     = rorWide[DW-1:0];
          carryOut = rorWide[DW-1];
        end
        default: carryValid = 1'b0;
      endcase
    end
  end

  always_comb begin
    if (ctl.hold) begin
      // R11
      hold_carry_chk: assert (opnd == src && carryOut == carryIn && !carryValid);
    end
    if (ctl.rrx && !ctl.hold) begin
      // R5
      rrx_fill_chk: assert (opnd[DW-1] == carryIn && carryOut == src[0]);
    end
    if (!ctl.hold && !ctl.rrx && ctl.kind == SH_LSL && ctl.amount > AMT_W'(DW)) begin
      // R8
      lsl_over_chk: assert (opnd == '0 && !carryOut);
    end
    if (!ctl.hold && !ctl.rrx && ctl.kind == SH_ASR && ctl.amount >= AMT_W'(DW)) begin
      // R9
      asr_fill_chk: assert (opnd == {DW{src[DW-1]}} && carryOut == src[DW-1]);
    end
    if (!ctl.hold && !ctl.rrx && ctl.kind == SH_ROR) begin
      // R2
      ror_carry_chk: assert (carryOut == opnd[DW-1] && carryValid);
    end
  end
endmodule

// File: rtl/op2_shifter.sv
module op2_shifter
  import op2_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic [DW-1:0] instrWord,
  input  logic [DW-1:0] rmValue,
  input  logic [DW-1:0] rsValue,
  input  logic          carryIn,
  output logic [DW-1:0] opnd,
  output logic          carryOut,
  output logic          carryValid
);
  op2_ctl_t ctl;

  op2_ctrl #(.DW(DW)) u_ctrl (
    .instrWord (instrWord),
    .rsValue   (rsValue),
    .ctl       (ctl)
  );

  op2_datapath #(.DW(DW)) u_dp (
    .ctl        (ctl),
    .rmValue    (rmValue),
    .carryIn    (carryIn),
    .opnd       (opnd),
    .carryOut   (carryOut),
    .carryValid (carryValid)
  );
endmodule

// File: tb/op2_shifter_test.sv
module op2_shifter_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic [31:0] instrWord = '0;
  logic [31:0] rmValue = '0;
  logic [31:0] rsValue = '0;
  logic        carryIn = 1'b0;
  logic [31:0] opnd;
  logic        carryOut;
  logic        carryValid;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  op2_shifter uut (
    .instrWord  (instrWord),
    .rmValue    (rmValue),
    .rsValue    (rsValue),
    .carryIn    (carryIn),
    .opnd       (opnd),
    .carryOut   (carryOut),
    .carryValid (carryValid)
  );

  // bit-serial reference: one bit moved per step, last bit out is the carry
  function automatic logic [33:0] refModel(input logic [31:0] iw, input logic [31:0] rm,
                                           input logic [31:0] rs, input logic cin);
    logic [31:0] v;
    logic        c;
    int          n;
    int          kind;
    bit          rrx;
    c   = cin;
    rrx = 1'b0;
    if (iw[25]) begin
      v    = {24'd0, iw[7:0]};
      n    = 2 * int'(iw[11:8]);
      kind = 3;
    end else begin
      v    = rm;
      kind = int'(iw[6:5]);
      if (iw[4]) n = int'(rs[7:0]);
      else begin
        n = int'(iw[11:7]);
        if (n == 0 && (kind == 1 || kind == 2)) n = 32;
        if (n == 0 && kind == 3) rrx = 1'b1;
      end
    end
    if (rrx) begin
      c = v[0];
      v = {cin, v[31:1]};
      return {1'b1, c, v};
    end
    for (int i = 0; i < n; i++) begin
      case (kind)
        0: begin c = v[31]; v = {v[30:0], 1'b0}; end
        1: begin c = v[0];  v = {1'b0, v[31:1]}; end
        2: begin c = v[0];  v = {v[31], v[31:1]}; end
        default: begin c = v[0]; v = {v[0], v[31:1]}; end
      endcase
    end
    return {n != 0, c, v};
  endfunction

  task automatic apply(input logic [31:0] iw, input logic [31:0] rm,
                       input logic [31:0] rs, input logic cin, input string tag);
    logic [33:0] exp;
    @(posedge clk);
    instrWord = iw;
    rmValue   = rm;
    rsValue   = rs;
    carryIn   = cin;
    @(negedge clk);
    exp = refModel(iw, rm, rs, cin);
    checks++;
    if (opnd !== exp[31:0] || carryOut !== exp[32] || carryValid !== exp[33]) begin
      errors++;
      $display("FAIL %s iw=%h rm=%h rs=%h cin=%b: got opnd=%h c=%b v=%b, expected opnd=%h c=%b v=%b",
               tag, iw, rm, rs, cin, opnd, carryOut, carryValid, exp[31:0], exp[32], exp[33]);
    end
  endtask

  function automatic logic [31:0] mkImm(input logic [3:0] rot, input logic [7:0] imm);
    return (32'd1 << 25) | ({28'd0, rot} << 8) | {24'd0, imm};
  endfunction
  function automatic logic [31:0] mkSi(input logic [4:0] amt, input logic [1:0] kind);
    return ({27'd0, amt} << 7) | ({30'd0, kind} << 5);
  endfunction
  function automatic logic [31:0] mkSr(input logic [1:0] kind);
    return (32'd1 << 4) | ({30'd0, kind} << 5);
  endfunction

  initial begin
    // initial all-zero inputs: pass-through of zero, carry held (R11)
    apply(32'd0, 32'd0, 32'd0, 1'b0, "R11 initial");
    // R1 rotated immediate
    apply(mkImm(4'h4, 8'hAB), 32'hDEAD_BEEF, 32'd0, 1'b0, "R1 imm ror8");
    apply(mkImm(4'hF, 8'hC3), 32'd0, 32'd0, 1'b0, "R1 imm ror30");
    // R2 rotated-immediate carry
    apply(mkImm(4'h0, 8'hFF), 32'd0, 32'd0, 1'b1, "R2 imm rot0");
    apply(mkImm(4'h1, 8'h01), 32'd0, 32'd0, 1'b1, "R2 imm ror2");
    // R3 logical left immediate
    apply(mkSi(5'd0, 2'b00), 32'h8000_0001, 32'd0, 1'b1, "R3 lsl0");
    apply(mkSi(5'd1, 2'b00), 32'h8000_0001, 32'd0, 1'b0, "R3 lsl1");
    apply(mkSi(5'd31, 2'b00), 32'h0000_0003, 32'd0, 1'b0, "R3 lsl31");
    // R4 zero immediate on right shifts
    apply(mkSi(5'd0, 2'b01), 32'h8000_0000, 32'd0, 1'b0, "R4 lsr32");
    apply(mkSi(5'd0, 2'b10), 32'h8000_0000, 32'd0, 1'b0, "R4 asr32");
    // R5 rotate through carry
    apply(mkSi(5'd0, 2'b11), 32'h0000_0003, 32'd0, 1'b1, "R5 rrx c1");
    apply(mkSi(5'd0, 2'b11), 32'h0000_0002, 32'd0, 1'b0, "R5 rrx c0");
    // R6 nonzero right shifts
    apply(mkSi(5'd4, 2'b01), 32'h0000_0018, 32'd0, 1'b0, "R6 lsr4");
    apply(mkSi(5'd31, 2'b10), 32'hC000_0000, 32'd0, 1'b0, "R6 asr31");
    apply(mkSi(5'd8, 2'b11), 32'h1234_5680, 32'd0, 1'b0, "R6 ror8");
    // R7 register amount low byte only
    apply(mkSr(2'b00), 32'h1234_5678, 32'h0000_0100, 1'b1, "R7 lsl reg 0x100");
    apply(mkSr(2'b01), 32'h8000_0000, 32'hFFFF_FF01, 1'b0, "R7 lsr reg low 1");
    // R8 register 32 and above
    apply(mkSr(2'b00), 32'h0000_0001, 32'd32, 1'b0, "R8 lsl 32");
    apply(mkSr(2'b01), 32'h8000_0000, 32'd32, 1'b0, "R8 lsr 32");
    apply(mkSr(2'b00), 32'hFFFF_FFFF, 32'd33, 1'b1, "R8 lsl 33");
    apply(mkSr(2'b01), 32'hFFFF_FFFF, 32'd255, 1'b1, "R8 lsr 255");
    // R9 arithmetic right 32 and above
    apply(mkSr(2'b10), 32'h8000_0000, 32'd200, 1'b0, "R9 asr 200");
    apply(mkSr(2'b10), 32'h7FFF_FFFF, 32'd32, 1'b1, "R9 asr 32");
    // R10 rotate modulo 32
    apply(mkSr(2'b11), 32'h8000_0000, 32'd32, 1'b0, "R10 ror 32");
    apply(mkSr(2'b11), 32'h0000_00F0, 32'd36, 1'b0, "R10 ror 36");
    apply(mkSr(2'b11), 32'h7FFF_FFFF, 32'd64, 1'b1, "R10 ror 64");
    // R11 random sweep over all forms, both carry-in values
    for (int k = 0; k < 3000; k++) begin
      logic [31:0] iw, rm, rs;
      iw = $urandom();
      rm = $urandom();
      rs = $urandom();
      if (k % 4 == 0) rs = rs & 32'h0000_003F;
      apply(iw, rm, rs, 1'b0, "R11 random c0");
      apply(iw, rm, rs, 1'b1, "R11 random c1");
    end
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule